// File: doc/BRIEF.md
# VGA Line Timer with Scanline Interrupt

This block is the horizontal timebase for a 640x480 raster driven at the 25.175 MHz pixel rate. A pixel counter runs through an 800-clock line (about 32 µs), and a line counter steps through a 525-line frame. The timer drives the active-low horizontal sync directly. The vertical sync is not decoded from the counters. Instead, software drives it through a one-bit control write, using the line number that the timer reports.

To let software keep pace with the raster, the timer raises an interrupt request when each scanline begins. The request stays pending until the processor acknowledges it. The timer also reports the current line number, a flag for lines inside the visible area, a flag for the visible part of the line, and a strobe that marks every fourth pixel clock. That strobe is the 160 ns processor cycle.

The default porch and sync widths follow the common 640x480 timing: 640 visible clocks, a 16-clock front porch, a 96-clock sync and a 48-clock back porch. Every width is a parameter.

Top module: `vga_line_timer`

## Requirements
- R1: While reset is low, line_num is 0, irq_req is 0, hsync_n and vsync_n are 1, and line_vis, pix_active and cyc_stb are 1. The pixel position is held at 0.
- R2: line_num increments once every H_TOTAL clocks (800 by default). The first increment comes 800 rising edges after reset is released.
- R3: After the line numbered V_TOTAL-1 (524 by default), line_num returns to 0.
- R4: line_vis is 1 exactly while line_num is below V_VISIBLE (480 by default).
- R5: hsync_n is 0 for H_SYNC clocks (96) and 1 at all other times. The low pulse covers line positions 656 to 751 inclusive, where position 0 is the first clock of a line.
- R6: pix_active is 1 for line positions 0 to 639 and 0 for positions 640 to 799.
- R7: irq_req becomes 1 on the same edge that line_num advances, including the wrap to 0. It is never set at any other point in the line.
- R8: A pending irq_req stays at 1 until irq_ack is sampled high, and then clears on that edge. If an acknowledge and a new line start arrive on the same edge, the request stays at 1.
- R9: cyc_stb is 1 on line positions that are multiples of 4 (0, 4, 8, ...) and 0 on all other positions. It is therefore never high on two clocks in a row.
- R10: When vsync_wr is sampled high, vsync_n takes the inverse of vsync_val on that edge, so writing 1 drives the sync low. Without a write, vsync_n holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, 25.175 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_ack | input | 1 | Clears a pending line-start request |
| vsync_wr | input | 1 | Write strobe for the vertical sync control bit |
| vsync_val | input | 1 | Value written; 1 asserts vertical sync |
| hsync_n | output | 1 | Active-low horizontal sync |
| vsync_n | output | 1 | Active-low vertical sync, software driven |
| cyc_stb | output | 1 | One-clock strobe every fourth pixel clock |
| pix_active | output | 1 | High in the visible part of the line |
| irq_req | output | 1 | Pending line-start interrupt request |
| line_num | output | LINE_W | Current line number |
| line_vis | output | 1 | High on visible lines |

## Verification
The pixel position, line number and interrupt are registered, so line_num and irq_req both change on the edge that ends line position 799. The bench counts rising edges after reset is released and samples on the falling edge that follows, where the line position equals that edge count. hsync_n, pix_active, cyc_stb and line_vis are decoded from those registers without any further register stage, so they are checked on the same falling edge as the position they belong to. An acknowledge or a vsync write takes effect one edge after it is driven, and the bench checks it on the next falling edge.

// File: rtl/vlt_pkg.sv
// Shared types for the line timer.
// Assumes: nothing beyond SystemVerilog 2017 packages.
package vlt_pkg;

    // Per-pixel horizontal phase flags decoded from the pixel counter.
    typedef struct packed {
        logic active;   // inside the visible span of the line
        logic sync;     // inside the horizontal sync pulse (active high)
        logic stb;      // processor cycle strobe
    } hphase_t;

endpackage

// File: rtl/vlt_pixel_cnt.sv
// Pixel position counter within one scanline.
// Counts 0..H_TOTAL-1 and wraps; flags the last position of the line.
// Assumes: H_TOTAL >= 2 and fits in CNT_W bits.
module vlt_pixel_cnt #(
    parameter int H_TOTAL = 800,
    parameter int CNT_W   = $clog2(H_TOTAL)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] pos,
    output logic             line_end
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(H_TOTAL - 1);

    assign line_end = (pos == LAST);

    // Advance the pixel position, wrapping at the end of the line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (line_end)
            pos <= '0;
        else
            pos <= pos + 1'b1;
    end
endmodule

// File: rtl/vlt_hdecode.sv
// Combinational decode of the pixel position into horizontal phase flags.
// Assumes: visible span starts at position 0, followed by front porch,
// sync and back porch; CYC_DIV >= 1.
module vlt_hdecode
    import vlt_pkg::*;
#(
    parameter int H_VISIBLE = 640,
    parameter int H_FRONT   = 16,
    parameter int H_SYNC    = 96,
    parameter int CYC_DIV   = 4,
    parameter int CNT_W     = 10
) (
    input  logic [CNT_W-1:0] pos,
    output hphase_t          phase
);
    localparam int SYNC_BEG = H_VISIBLE + H_FRONT;
    localparam int SYNC_END = SYNC_BEG + H_SYNC;
    localparam bit DIV_POW2 = (CYC_DIV & (CYC_DIV - 1)) == 0;

    logic stb;

    // Pick the strobe decoder that suits the divide ratio.
    generate
        if (CYC_DIV == 1) begin : g_stb_all
            assign stb = 1'b1;
        end else if (DIV_POW2) begin : g_stb_pow2
            localparam int DIV_W = $clog2(CYC_DIV);
            assign stb = (pos[DIV_W-1:0] == '0);
        end else begin : g_stb_mod
            assign stb = ((pos % CNT_W'(CYC_DIV)) == '0);
        end
    endgenerate

    // Compare the position against the span boundaries.
    always_comb begin
        phase.active = (pos < CNT_W'(H_VISIBLE));
        phase.sync   = (pos >= CNT_W'(SYNC_BEG)) && (pos < CNT_W'(SYNC_END));
        phase.stb    = stb;
    end
endmodule

// File: rtl/vlt_line_cnt.sv
// Scanline counter for one frame.
// Steps once per line and wraps after V_TOTAL lines; flags visible lines.
// Assumes: visible lines are numbered from 0; V_VISIBLE <= V_TOTAL.
module vlt_line_cnt #(
    parameter int V_TOTAL   = 525,
    parameter int V_VISIBLE = 480,
    parameter int LINE_W    = $clog2(V_TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [LINE_W-1:0] line,
    output logic              visible
);
    localparam logic [LINE_W-1:0] LAST = LINE_W'(V_TOTAL - 1);

    assign visible = (line < LINE_W'(V_VISIBLE));

    // Step the line number at each line end, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line <= '0;
        else if (advance)
            line <= (line == LAST) ? '0 : line + 1'b1;
    end
endmodule

// File: rtl/vlt_irq_latch.sv
// Pending-request flag for the line-start interrupt.
// A set event wins over an acknowledge arriving on the same edge.
// Assumes: set and ack are synchronous to clk.
module vlt_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic pending
);
    // Hold the request until acknowledged; a new set re-arms it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (set)
            pending <= 1'b1;
        else if (ack)
            pending <= 1'b0;
    end
endmodule

// File: rtl/vga_line_timer.sv
// Top of the line timer: pixel and line counters, horizontal sync,
// cycle strobe, line-start interrupt and a software-driven vertical sync.
// Assumes: clk is the pixel clock; all inputs are synchronous to it.
module vga_line_timer
    import vlt_pkg::*;
#(
    parameter int H_VISIBLE = 640,
    parameter int H_FRONT   = 16,
    parameter int H_SYNC    = 96,
    parameter int H_BACK    = 48,
    parameter int V_TOTAL   = 525,
    parameter int V_VISIBLE = 480,
    parameter int CYC_DIV   = 4,
    parameter int LINE_W    = $clog2(V_TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_ack,
    input  logic              vsync_wr,
    input  logic              vsync_val,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              cyc_stb,
    output logic              pix_active,
    output logic              irq_req,
    output logic [LINE_W-1:0] line_num,
    output logic              line_vis
);
    localparam int H_TOTAL = H_VISIBLE + H_FRONT + H_SYNC + H_BACK;
    localparam int CNT_W   = $clog2(H_TOTAL);

    logic [CNT_W-1:0] pos;
    logic             line_end;
    hphase_t          phase;

    vlt_pixel_cnt #(.H_TOTAL(H_TOTAL), .CNT_W(CNT_W)) u_pix (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos      (pos),
        .line_end (line_end)
    );

    vlt_hdecode #(
        .H_VISIBLE (H_VISIBLE),
        .H_FRONT   (H_FRONT),
        .H_SYNC    (H_SYNC),
        .CYC_DIV   (CYC_DIV),
        .CNT_W     (CNT_W)
    ) u_dec (
        .pos   (pos),
        .phase (phase)
    );

    vlt_line_cnt #(.V_TOTAL(V_TOTAL), .V_VISIBLE(V_VISIBLE), .LINE_W(LINE_W)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (line_end),
        .line    (line_num),
        .visible (line_vis)
    );

    vlt_irq_latch u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (line_end),
        .ack     (irq_ack),
        .pending (irq_req)
    );

    assign hsync_n    = ~phase.sync;
    assign pix_active = phase.active;
    assign cyc_stb    = phase.stb;

    // Hold the software-written vertical sync level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vsync_n <= 1'b1;
        else if (vsync_wr)
            vsync_n <= ~vsync_val;
    end
endmodule

// File: rtl/vlt_checker.sv
// Protocol checker for the line timer, attached by bind.
// Assumes: default CYC_DIV > 1 for the strobe spacing check.
module vlt_checker #(
    parameter int H_SYNC    = 96,
    parameter int V_TOTAL   = 525,
    parameter int V_VISIBLE = 480,
    parameter int CYC_DIV   = 4,
    parameter int LINE_W    = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_ack,
    input logic              vsync_wr,
    input logic              vsync_val,
    input logic              hsync_n,
    input logic              vsync_n,
    input logic              cyc_stb,
    input logic              irq_req,
    input logic [LINE_W-1:0] line_num,
    input logic              line_vis
);
    logic [15:0] low_run;

    // Count consecutive clocks with horizontal sync asserted.
    always_ff @(posedge clk) begin
        if (!rst_n || hsync_n)
            low_run <= '0;
        else
            low_run <= low_run + 1'b1;
    end

    assert_hsync_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> (low_run == 16'(H_SYNC)));

    assert_line_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_num < LINE_W'(V_TOTAL));

    assert_vis_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_vis) |-> (line_num == '0));

    assert_vis_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_vis) |-> (line_num == LINE_W'(V_VISIBLE)));

    assert_irq_on_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> (line_num != $past(line_num)));

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> irq_req);

    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (!irq_req || (line_num != $past(line_num))));

    assert_stb_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && (CYC_DIV > 1)) |=> !cyc_stb);

    assert_vsync_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_wr |=> (vsync_n == !$past(vsync_val)));

    assert_vsync_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_wr |=> $stable(vsync_n));
endmodule

bind vga_line_timer vlt_checker #(
    .H_SYNC    (H_SYNC),
    .V_TOTAL   (V_TOTAL),
    .V_VISIBLE (V_VISIBLE),
    .CYC_DIV   (CYC_DIV),
    .LINE_W    (LINE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_ack   (irq_ack),
    .vsync_wr  (vsync_wr),
    .vsync_val (vsync_val),
    .hsync_n   (hsync_n),
    .vsync_n   (vsync_n),
    .cyc_stb   (cyc_stb),
    .irq_req   (irq_req),
    .line_num  (line_num),
    .line_vis  (line_vis)
);

// File: tb/sim_vga_line_timer.sv
// Bench for the line timer: horizontal vector table, then directed tests.
// The frame is shortened to 12 lines (8 visible) to bound the run length.
module sim_vga_line_timer;
    localparam int CLK_PERIOD = 40;
    localparam int VT = 12;
    localparam int VV = 8;
    localparam int LW = 10;
    localparam int NV = 11;
    // {line position, expected hsync_n, pix_active, cyc_stb}
    localparam logic [12:0] VEC [NV] = '{
        {10'd0,   3'b111}, {10'd1,   3'b110}, {10'd3,   3'b110},
        {10'd4,   3'b111}, {10'd639, 3'b110}, {10'd640, 3'b101},
        {10'd655, 3'b100}, {10'd656, 3'b001}, {10'd751, 3'b000},
        {10'd752, 3'b101}, {10'd799, 3'b100}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_ack = 1'b0;
    logic vsync_wr = 1'b0;
    logic vsync_val = 1'b0;
    logic hsync_n, vsync_n, cyc_stb, pix_active, irq_req, line_vis;
    logic [LW-1:0] line_num;

    int checks = 0;
    int fails = 0;
    int tick = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vga_line_timer #(.V_TOTAL(VT), .V_VISIBLE(VV), .LINE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .vsync_wr(vsync_wr),
        .vsync_val(vsync_val), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .cyc_stb(cyc_stb), .pix_active(pix_active), .irq_req(irq_req),
        .line_num(line_num), .line_vis(line_vis)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at tick %0d: got %0d expected %0d", req, tick, act, exp);
        end
    endtask

    // Move forward n rising edges, landing on a falling edge.
    task automatic go(input int n);
        repeat (n) @(negedge clk);
        tick += n;
    endtask

    task automatic go_to(input int t);
        go(t - tick);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 line_num", int'(line_num), 0);
        chk("R1 irq_req", int'(irq_req), 0);
        chk("R1 hsync_n", int'(hsync_n), 1);
        chk("R1 vsync_n", int'(vsync_n), 1);
        chk("R1 line_vis", int'(line_vis), 1);
        chk("R1 pix_active", int'(pix_active), 1);
        chk("R1 cyc_stb", int'(cyc_stb), 1);
        rst_n = 1'b1;
        tick = 0;

        // Table walk over one line: R5 sync, R6 active, R9 strobe, R7 quiet
        for (int i = 0; i < NV; i++) begin
            go_to(int'(VEC[i][12:3]));
            chk("R5 hsync_n", int'(hsync_n), int'(VEC[i][2]));
            chk("R6 pix_active", int'(pix_active), int'(VEC[i][1]));
            chk("R9 cyc_stb", int'(cyc_stb), int'(VEC[i][0]));
            chk("R7 no irq in line 0", int'(irq_req), 0);
            chk("R2 still line 0", int'(line_num), 0);
        end

        // R2 and R7: first line boundary
        go_to(800);
        chk("R2 line_num after 800", int'(line_num), 1);
        chk("R7 irq at line start", int'(irq_req), 1);

        // R8: pending request held, then cleared by acknowledge
        go_to(850);
        chk("R8 irq held", int'(irq_req), 1);
        irq_ack = 1'b1;
        go(1);
        irq_ack = 1'b0;
        chk("R8 irq cleared", int'(irq_req), 0);
        go(1);
        chk("R8 irq stays clear", int'(irq_req), 0);

        // R8: set wins over acknowledge on the same edge
        go_to(1599);
        chk("R2 line 1 before boundary", int'(line_num), 1);
        irq_ack = 1'b1;
        go(1);
        irq_ack = 1'b0;
        chk("R8 set wins", int'(irq_req), 1);
        chk("R2 line 2", int'(line_num), 2);
        irq_ack = 1'b1;
        go(1);
        irq_ack = 1'b0;

        // R10: software vertical sync
        vsync_wr = 1'b1; vsync_val = 1'b1;
        go(1);
        vsync_wr = 1'b0; vsync_val = 1'b0;
        chk("R10 vsync asserted", int'(vsync_n), 0);
        go(5);
        chk("R10 vsync held", int'(vsync_n), 0);
        vsync_wr = 1'b1;
        go(1);
        vsync_wr = 1'b0;
        chk("R10 vsync released", int'(vsync_n), 1);

        // R4: visible boundary
        go_to(VV * 800 - 1);
        chk("R4 last visible line", int'(line_num), VV - 1);
        chk("R4 vis on last visible", int'(line_vis), 1);
        go(1);
        chk("R4 first blank line", int'(line_num), VV);
        chk("R4 vis off", int'(line_vis), 0);

        // R3: frame wrap
        irq_ack = 1'b1;
        go_to(VT * 800 - 1);
        irq_ack = 1'b0;
        chk("R3 last line", int'(line_num), VT - 1);
        chk("R7 irq cleared before wrap", int'(irq_req), 0);
        go(1);
        chk("R3 wrap to 0", int'(line_num), 0);
        chk("R4 vis after wrap", int'(line_vis), 1);
        chk("R7 irq at wrap", int'(irq_req), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule